// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block is the timekeeping core of an on-chip real-time clock. A 128 Hz tick strobe drives a 7-bit binary sub-second counter. Each time that counter wraps, the seconds field advances, and the carry then ripples through minutes, hours, weekday, day of month, month and a four-digit year. Every calendar field is held in packed BCD. The day-of-month rollover follows the length of the current month and the Gregorian leap-year rule.

Software uses a small register bus with a write strobe and a combinational read port to stop the counter, load a new time and start it again. Any carry that happens between the reads of several fields raises a sticky flag. Software clears that flag before reading the fields and looks at it again afterwards to tell whether the reads were torn. A control write can also round the seconds to the nearest minute.

Top module: `bcdclk_top`

## Requirements
- R1: Register indices are 0 sub-second (binary, bits 6:0), 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year (16 bits), 8 control A and 9 control B. Reads are zero-extended to 16 bits. After reset the time is 00:00:00, weekday 0, day 01, month 01, year 2000, and both control registers read 0.
- R2: The calendar fields are packed BCD with these ranges: seconds and minutes 00–59, hours 00–23, weekday 0–6, month 01–12.
- R3: While running, each tick adds one to the sub-second counter. When the counter wraps from 127 to 0, seconds advance by one on the same clock edge.
- R4: A seconds rollover from 59 carries into minutes, minutes carry into hours, and hours roll from 23 to 00. A day rollover advances the weekday (6 wraps to 0) and the day of month, and a month rollover from 12 to 01 advances the year.
- R5: The day of month wraps to 01 after the last day of its month. April, June, September and November have 30 days and February has 28 days, or 29 in a leap year. A leap year is divisible by 4 and not by 100, unless it is divisible by 400.
- R6: The year field keeps the year within the century in BCD in bits 7:0 and the century in BCD in bits 15:8. Year 99 rolls to 00 and increments the century.
- R7: Control A bit 7 is the carry flag. Each seconds advance caused by a sub-second wrap sets it. Writing 0 to the bit clears it and writing 1 leaves it unchanged. A set on the same edge wins over a clear.
- R8: Control A bit 4 enables the carry interrupt. The output carryIrq is high exactly when both the carry flag and this enable are 1.
- R9: Control B bit 0 runs the counter and bit 3 is an enable bit that reads back as written. While bit 0 is 0, ticks have no effect and writes to indices 0–7 load the field. While bit 0 is 1, those writes are ignored.
- R10: Control B bit 1 holds the sub-second counter at 0 for as long as it is set, and ticks are ignored during that time.
- R11: A write to control B with bit 2 set performs a 30-second adjust on that edge. Seconds 00–29 become 00. Seconds 30–59 become 00 with a one-minute carry through the calendar. The sub-second counter is cleared, and bit 2 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 128 Hz tick, one clock cycle wide |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register index for both read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data at addr |
| carryIrq | output | 1 | Carry interrupt request |

## Verification
The range assertions assume that software loads only legal BCD values into every field while the counter is stopped. They also assume a day of month that is valid for the loaded month. The stimulus loads only such values. The stimulus never writes the adjust request on a cycle that also carries a tick, never loads a field and adjusts in the same write, and never drives a tick closer than two cycles after another. The hold assertion expects the calendar fields to stay fixed whenever no tick, load or adjust is active. The stimulus therefore checks results only after each write or tick has settled.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;
  localparam int SUB_W = 7;
  localparam int FIELD_CNT = 8;

  typedef struct packed {
    logic [SUB_W-1:0] sub;
    logic [7:0]       sec;
    logic [7:0]       min;
    logic [7:0]       hour;
    logic [7:0]       wday;
    logic [7:0]       mday;
    logic [7:0]       mon;
    logic [15:0]      year;
  } timeT;

  typedef struct packed {
    logic                 countEn;
    logic                 preHold;
    logic                 adjust;
    logic [FIELD_CNT-1:0] load;
  } strobeT;

  function automatic logic [7:0] bcdInc8(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic int bcdToBin(input logic [7:0] v);
    return 10 * int'(v[7:4]) + int'(v[3:0]);
  endfunction

  function automatic logic isLeap(input logic [15:0] y);
    int yy;
    int cc;
    yy = bcdToBin(y[7:0]);
    cc = bcdToBin(y[15:8]);
    if (yy != 0) return (yy % 4) == 0;
    return (cc % 4) == 0;
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] m, input logic leap);
    case (m)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcdclk_ctrl.sv
module bcdclk_ctrl
  import bcdclk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              secCarry,
  input  timeT              timeNow,
  output strobeT            strb,
  output logic [DATA_W-1:0] rdData,
  output logic              carryIrq
);
  localparam int IDX_CTLA = FIELD_CNT;
  localparam int IDX_CTLB = FIELD_CNT + 1;
  localparam int B_FLAG = 7;
  localparam int B_CIE  = 4;
  localparam int B_RUN  = 0;
  localparam int B_PRE  = 1;
  localparam int B_ADJ  = 2;
  localparam int B_EN   = 3;

  logic carryFlag, carryIe, runBit, preBit, enBit;
  logic wrA, wrB;
  wire unusedCtl = ^{wrData[DATA_W-1:8], wrData[6:5]};

  assign wrA = wrEn && (addr == ADDR_W'(IDX_CTLA));
  assign wrB = wrEn && (addr == ADDR_W'(IDX_CTLB));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryFlag <= 1'b0;
      carryIe   <= 1'b0;
      runBit    <= 1'b0;
      preBit    <= 1'b0;
      enBit     <= 1'b0;
    end else begin
      if (secCarry) carryFlag <= 1'b1;
      else if (wrA && !wrData[B_FLAG]) carryFlag <= 1'b0;
      if (wrA) carryIe <= wrData[B_CIE];
      if (wrB) begin
        runBit <= wrData[B_RUN];
        preBit <= wrData[B_PRE];
        enBit  <= wrData[B_EN];
      end
    end
  end

  assign strb.countEn = tick && runBit && !preBit;
  assign strb.preHold = preBit;
  assign strb.adjust  = wrB && wrData[B_ADJ];

  for (genvar i = 0; i < FIELD_CNT; i++) begin : g_load
    assign strb.load[i] = wrEn && !runBit && (addr == ADDR_W'(i));
  end

  always_comb begin
    rdData = '0;
    case (int'(addr))
      0:        rdData = DATA_W'(timeNow.sub);
      1:        rdData = DATA_W'(timeNow.sec);
      2:        rdData = DATA_W'(timeNow.min);
      3:        rdData = DATA_W'(timeNow.hour);
      4:        rdData = DATA_W'(timeNow.wday);
      5:        rdData = DATA_W'(timeNow.mday);
      6:        rdData = DATA_W'(timeNow.mon);
      7:        rdData = DATA_W'(timeNow.year);
      IDX_CTLA: rdData = DATA_W'({carryFlag, 2'b00, carryIe, 4'b0000});
      IDX_CTLB: rdData = DATA_W'({enBit, 1'b0, preBit, runBit});
      default:  rdData = '0;
    endcase
  end

  assign carryIrq = carryFlag && carryIe;

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    (carryFlag && !$past(carryFlag)) |-> $past(secCarry));

  assert_no_count_stopped_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(runBit) && !$past(strb.adjust) && $past(strb.load) == '0)
      |-> $stable(timeNow.sec));
endmodule

// File: rtl/bcdclk_datapath.sv
module bcdclk_datapath
  import bcdclk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobeT      strb,
  input  logic [15:0] wrData,
  output logic        secCarry,
  output timeT        timeNow
);
  localparam logic [SUB_W-1:0] SUB_MAX = '1;

  timeT cur, nxt;
  logic leapNow;
  logic [7:0] dimNow;

  assign secCarry = strb.countEn && (cur.sub == SUB_MAX);
  assign leapNow  = isLeap(cur.year);
  assign dimNow   = lastDay(cur.mon, leapNow);
  assign timeNow  = cur;

  always_comb begin
    logic secStep, minStep, hrStep, dayStep, monStep, yrStep;
    nxt = cur;
    minStep = 1'b0; hrStep = 1'b0; dayStep = 1'b0; monStep = 1'b0; yrStep = 1'b0;
    secStep = 1'b0;

    if (strb.adjust) begin
      nxt.sub = '0;
      nxt.sec = 8'h00;
      minStep = (cur.sec >= 8'h30);
    end else if (strb.countEn) begin
      nxt.sub = cur.sub + 1'b1;
      secStep = secCarry;
    end

    if (secStep) begin
      if (cur.sec == 8'h59) begin
        nxt.sec = 8'h00;
        minStep = 1'b1;
      end else nxt.sec = bcdInc8(cur.sec);
    end
    if (minStep) begin
      if (cur.min == 8'h59) begin
        nxt.min = 8'h00;
        hrStep  = 1'b1;
      end else nxt.min = bcdInc8(cur.min);
    end
    if (hrStep) begin
      if (cur.hour == 8'h23) begin
        nxt.hour = 8'h00;
        dayStep  = 1'b1;
      end else nxt.hour = bcdInc8(cur.hour);
    end
    if (dayStep) begin
      nxt.wday = (cur.wday == 8'h06) ? 8'h00 : cur.wday + 8'h01;
      if (cur.mday == dimNow) begin
        nxt.mday = 8'h01;
        monStep  = 1'b1;
      end else nxt.mday = bcdInc8(cur.mday);
    end
    if (monStep) begin
      if (cur.mon == 8'h12) begin
        nxt.mon = 8'h01;
        yrStep  = 1'b1;
      end else nxt.mon = bcdInc8(cur.mon);
    end
    if (yrStep) begin
      if (cur.year[7:0] == 8'h99) begin
        nxt.year[7:0]  = 8'h00;
        nxt.year[15:8] = (cur.year[15:8] == 8'h99) ? 8'h00 : bcdInc8(cur.year[15:8]);
      end else nxt.year[7:0] = bcdInc8(cur.year[7:0]);
    end

    if (strb.load[0]) nxt.sub  = wrData[SUB_W-1:0];
    if (strb.load[1]) nxt.sec  = wrData[7:0];
    if (strb.load[2]) nxt.min  = wrData[7:0];
    if (strb.load[3]) nxt.hour = wrData[7:0];
    if (strb.load[4]) nxt.wday = wrData[7:0];
    if (strb.load[5]) nxt.mday = wrData[7:0];
    if (strb.load[6]) nxt.mon  = wrData[7:0];
    if (strb.load[7]) nxt.year = wrData;

    if (strb.preHold) nxt.sub = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur.sub  <= '0;
      cur.sec  <= 8'h00;
      cur.min  <= 8'h00;
      cur.hour <= 8'h00;
      cur.wday <= 8'h00;
      cur.mday <= 8'h01;
      cur.mon  <= 8'h01;
      cur.year <= 16'h2000;
    end else begin
      cur <= nxt;
    end
  end

  assert_sec_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cur.sec[3:0] <= 4'd9) && (cur.sec <= 8'h59));

  assert_month_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cur.mon >= 8'h01) && (cur.mon <= 8'h12) && (cur.mon[3:0] <= 4'd9));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (secCarry && !strb.preHold && strb.load == '0) |=> (cur.sub == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEn && !strb.adjust && strb.load == '0)
      |=> ($stable(cur.sec) && $stable(cur.min) && $stable(cur.mday) && $stable(cur.year)));

  assert_prescaler_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.preHold |=> (cur.sub == '0));

  assert_adjust_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.adjust |=> (cur.sec == 8'h00));
endmodule

// File: rtl/bcdclk_top.sv
module bcdclk_top
  import bcdclk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              carryIrq
);
  strobeT strb;
  timeT   timeNow;
  logic   secCarry;

  bcdclk_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .secCarry(secCarry), .timeNow(timeNow),
    .strb(strb), .rdData(rdData), .carryIrq(carryIrq)
  );

  bcdclk_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData[15:0]),
    .secCarry(secCarry), .timeNow(timeNow)
  );
endmodule

// File: tb/bcdclk_top_tb.sv
module bcdclk_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        carryIrq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    bit          isIrq;
    logic [15:0] exp;
    string       tag;
  } itemT;
  itemT sbq[$];
  event sampleEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcdclk_top u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .carryIrq(carryIrq)
  );

  // monitor: pops the next expected item and compares against the outputs
  initial begin
    forever begin
      @(sampleEv);
      #1;
      if (sbq.size() > 0) begin
        itemT it;
        logic [15:0] act;
        it = sbq.pop_front();
        act = it.isIrq ? {15'd0, carryIrq} : rdData;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expRd(input logic [3:0] a, input logic [15:0] e, input string tag);
    itemT it;
    @(negedge clk);
    addr = a;
    it.isIrq = 0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    -> sampleEv;
    #2;
  endtask

  task automatic expIrq(input logic e, input string tag);
    itemT it;
    @(negedge clk);
    it.isIrq = 1; it.exp = {15'd0, e}; it.tag = tag;
    sbq.push_back(it);
    -> sampleEv;
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic setTime(input bit run, input logic [7:0] sub, input logic [7:0] s,
                         input logic [7:0] m, input logic [7:0] h, input logic [7:0] wd,
                         input logic [7:0] md, input logic [7:0] mo, input logic [15:0] y);
    wr(4'd9, 16'h0000);
    wr(4'd0, {8'h00, sub});
    wr(4'd1, {8'h00, s});
    wr(4'd2, {8'h00, m});
    wr(4'd3, {8'h00, h});
    wr(4'd4, {8'h00, wd});
    wr(4'd5, {8'h00, md});
    wr(4'd6, {8'h00, mo});
    wr(4'd7, y);
    if (run) wr(4'd9, 16'h0009);
  endtask

  // roll over one day boundary from 23:59:59.127 and check the date
  task automatic dayRoll(input logic [7:0] md, input logic [7:0] mo, input logic [15:0] y,
                         input logic [7:0] expMd, input logic [7:0] expMo, input string tag);
    setTime(1, 8'h7F, 8'h59, 8'h59, 8'h23, 8'h03, md, mo, y);
    ticks(1);
    expRd(4'd5, {8'h00, expMd}, tag);
    expRd(4'd6, {8'h00, expMo}, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expRd(4'd0, 16'h0000, "R1 sub reset");
    expRd(4'd1, 16'h0000, "R1 sec reset");
    expRd(4'd3, 16'h0000, "R1 hour reset");
    expRd(4'd4, 16'h0000, "R1 wday reset");
    expRd(4'd5, 16'h0001, "R1 mday reset");
    expRd(4'd6, 16'h0001, "R1 mon reset");
    expRd(4'd7, 16'h2000, "R1 year reset");
    expRd(4'd8, 16'h0000, "R1 ctlA reset");
    expRd(4'd9, 16'h0000, "R1 ctlB reset");
    expIrq(1'b0, "R8 irq reset");

    // R10 prescaler reset holds sub-second at zero while running
    wr(4'd9, 16'h000B);
    ticks(3);
    expRd(4'd0, 16'h0000, "R10 held");
    // R3 counting
    wr(4'd9, 16'h0009);
    ticks(5);
    expRd(4'd0, 16'h0005, "R3 count");
    // R9 field writes ignored while running, enable readback
    wr(4'd1, 16'h0033);
    expRd(4'd1, 16'h0000, "R9 write ignored running");
    expRd(4'd9, 16'h0009, "R9 ctlB readback");
    // R9 ticks ignored while stopped
    wr(4'd9, 16'h0000);
    ticks(2);
    expRd(4'd0, 16'h0005, "R9 stopped");

    // R4 R6 full cascade into century
    setTime(1, 8'h7E, 8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 16'h2099);
    ticks(1);
    expRd(4'd0, 16'h007F, "R3 before wrap");
    expRd(4'd1, 16'h0059, "R3 sec before wrap");
    expRd(4'd8, 16'h0000, "R7 flag clear before wrap");
    ticks(1);
    expRd(4'd0, 16'h0000, "R3 wrap");
    expRd(4'd1, 16'h0000, "R4 sec");
    expRd(4'd2, 16'h0000, "R4 min");
    expRd(4'd3, 16'h0000, "R4 hour");
    expRd(4'd4, 16'h0000, "R4 wday wrap");
    expRd(4'd5, 16'h0001, "R4 mday");
    expRd(4'd6, 16'h0001, "R4 mon");
    expRd(4'd7, 16'h2100, "R6 century");
    expRd(4'd8, 16'h0080, "R7 flag set");
    expIrq(1'b0, "R8 irq masked");
    wr(4'd9, 16'h0000);

    // R7 R8 flag and interrupt
    wr(4'd8, 16'h0090);
    expRd(4'd8, 16'h0090, "R7 write one keeps flag");
    expIrq(1'b1, "R8 irq asserted");
    wr(4'd8, 16'h0010);
    expRd(4'd8, 16'h0010, "R7 write zero clears");
    expIrq(1'b0, "R8 irq after clear");
    wr(4'd8, 16'h0080);
    expRd(4'd8, 16'h0000, "R7 write one does not set");

    // R5 month lengths and leap years
    dayRoll(8'h28, 8'h02, 16'h2024, 8'h29, 8'h02, "R5 leap 2024");
    dayRoll(8'h28, 8'h02, 16'h2100, 8'h01, 8'h03, "R5 non-leap 2100");
    dayRoll(8'h28, 8'h02, 16'h2000, 8'h29, 8'h02, "R5 leap 2000");
    dayRoll(8'h28, 8'h02, 16'h2023, 8'h01, 8'h03, "R5 non-leap 2023");
    dayRoll(8'h29, 8'h02, 16'h2024, 8'h01, 8'h03, "R5 feb 29 end");
    dayRoll(8'h30, 8'h04, 16'h2024, 8'h01, 8'h05, "R5 april end");
    dayRoll(8'h30, 8'h05, 16'h2024, 8'h31, 8'h05, "R5 may 30");
    expRd(4'd4, 16'h0004, "R4 wday step");
    dayRoll(8'h09, 8'h09, 16'h2024, 8'h10, 8'h09, "R2 bcd digit carry");

    // R11 30-second adjust
    setTime(0, 8'h40, 8'h29, 8'h10, 8'h05, 8'h01, 8'h15, 8'h06, 16'h2024);
    wr(4'd9, 16'h0004);
    expRd(4'd1, 16'h0000, "R11 round down sec");
    expRd(4'd2, 16'h0010, "R11 round down min");
    expRd(4'd0, 16'h0000, "R11 sub cleared");
    expRd(4'd9, 16'h0000, "R11 bit self clears");
    setTime(0, 8'h00, 8'h45, 8'h59, 8'h05, 8'h01, 8'h15, 8'h06, 16'h2024);
    wr(4'd9, 16'h0004);
    expRd(4'd1, 16'h0000, "R11 round up sec");
    expRd(4'd2, 16'h0000, "R11 round up min");
    expRd(4'd3, 16'h0006, "R11 round up hour");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule